// File: doc/BRIEF.md
# Debug Register Access Controller

This block serves an external debug tool that talks to the chip through coded messages. The message link hands it requests that are already decoded. Each request carries a transfer code, an access opcode and, for writes, a data word. The block reads or writes a small set of internal registers and answers every request with exactly one coded response message. Pin-level serialisation of the messages is handled elsewhere.

One of the registers is a control word. Writing it with its start/continue bit set launches one access, or a block of accesses, on an internal memory bus. The block acts as master on that bus and uses a request/acknowledge handshake. It forces each bus address onto the boundary of the programmed access size, and it steps the address by that size after every successful beat. If the bus reports an address error, the block abandons the remaining beats, clears the start/continue bit and sends a coded error message to the tool instead of the ready message.

Top module: `dbg_reg_access`

## Requirements
- R1: A request with transfer code 18 writes `req_data` into the register chosen by the opcode: 0x10 is the bus address register, 0x11 the control register and 0x14 the data register. Unless it launches bus work, it is answered by one response with transfer code 16 and data 0.
- R2: A request with transfer code 17 is answered by one response with transfer code 19 whose data is the selected register, zero-extended. The control register reads as bit 0 start/continue, bit 1 direction (1 = bus read), bits 3:2 size (0 byte, 1 half-word, 2 word, 3 treated as word) and bits 15:8 beat count.
- R3: An unknown opcode, or an unknown transfer code, changes no register. A write or an unknown code still gets transfer code 16, and a read of an unknown opcode gets transfer code 19 with data 0.
- R4: `req_ready` stays low from the acceptance of a request until its response has been taken. A response stays valid and unchanged while `rsp_ready` is low.
- R5: Writing the control register with bit 0 set starts bus accesses. The ready response (code 16) is sent only after the last beat completes, and the start/continue bit then reads back as 0. A control write with bit 0 clear starts no bus cycle.
- R6: A word access drives bus address bits 1:0 as 0, a half-word access drives bit 0 as 0, and a byte access uses the address unchanged.
- R7: A block transfer performs as many beats as the count field says, with 0 acting as 1. The address advances by 1, 2 or 4 bytes after each beat.
- R8: On a bus read, each acknowledged beat without error stores `bus_rdata` into the data register, so the last beat's data remains there.
- R9: On a bus write, `bus_we` is 1 and `bus_wdata` carries the data register.
- R10: An acknowledge that comes with `bus_err` ends the access with no retry and no further beats. The start/continue bit is cleared, and the response is transfer code 8 with data 0b00011.
- R11: `bus_req` is low when idle. Once raised, it stays high with a stable address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Block can accept a request |
| req_tcode | input | 6 | Request transfer code |
| req_opcode | input | 8 | Access opcode selecting a register |
| req_data | input | DATA_W | Write data of the request |
| rsp_valid | output | 1 | Response message present |
| rsp_ready | input | 1 | Tool takes the response |
| rsp_tcode | output | 6 | Response transfer code |
| rsp_data | output | DATA_W | Response data or error code |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | Bus cycle is a write |
| bus_size | output | 2 | Bus access size code |
| bus_addr | output | ADDR_W | Aligned bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ack | input | 1 | Bus cycle complete |
| bus_err | input | 1 | Address error, valid with bus_ack |

## Verification
Misaligned start addresses are used for every size. A design that failed to mask the low bits would show the raw address on the bus and, in a block transfer, would step from the wrong base. The count-zero case catches a design that treats zero as no beats or as a full wrap. The error case injects a fault on the second beat of a four-beat read. A faulty design would go on to the third beat, would report ready instead of code 8, or would leave the start/continue bit set. Unknown opcodes and codes are followed by read-backs of the data register, which expose a stray write. Responses are held back for a cycle to catch one that drops early or changes while waiting.

// File: rtl/dra_pkg.sv
package dra_pkg;

    localparam int TC_W  = 6;
    localparam int OP_W  = 8;
    localparam int ERR_W = 5;

    // transfer codes of the message protocol
    localparam logic [TC_W-1:0] TC_ERROR  = 6'd8;
    localparam logic [TC_W-1:0] TC_READY  = 6'd16;
    localparam logic [TC_W-1:0] TC_RD_REQ = 6'd17;
    localparam logic [TC_W-1:0] TC_WR_REQ = 6'd18;
    localparam logic [TC_W-1:0] TC_RD_RSP = 6'd19;

    localparam logic [ERR_W-1:0] ERR_ADDR = 5'b00011;

    // register opcodes
    localparam logic [OP_W-1:0] OPC_ADDR = 8'h10;
    localparam logic [OP_W-1:0] OPC_CTRL = 8'h11;
    localparam logic [OP_W-1:0] OPC_DATA = 8'h14;

    // control word layout
    localparam int CTRL_SC_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;
    localparam int CTRL_SZ_LSB  = 2;
    localparam int CTRL_CNT_LSB = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_REPLY
    } ctl_state_e;

endpackage

// File: rtl/dra_regs.sv
module dra_regs
    import dra_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OP_W-1:0]   wr_opc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sc_clr,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_data,
    input  logic [OP_W-1:0]   rd_opc,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              sc;
        logic              dir;
        logic [1:0]        size;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (upd_en) begin
            regs_d.data = upd_data;
        end
        if (sc_clr) begin
            regs_d.sc = 1'b0;
        end
        if (wr_en) begin
            case (wr_opc)
                OPC_ADDR: regs_d.addr = wr_data[ADDR_W-1:0];
                OPC_CTRL: begin
                    regs_d.sc   = wr_data[CTRL_SC_BIT];
                    regs_d.dir  = wr_data[CTRL_DIR_BIT];
                    regs_d.size = wr_data[CTRL_SZ_LSB +: 2];
                    regs_d.cnt  = wr_data[CTRL_CNT_LSB +: CNT_W];
                end
                OPC_DATA: regs_d.data = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_opc)
            OPC_ADDR: rd_data[ADDR_W-1:0] = regs_q.addr;
            OPC_CTRL: begin
                rd_data[CTRL_SC_BIT]              = regs_q.sc;
                rd_data[CTRL_DIR_BIT]             = regs_q.dir;
                rd_data[CTRL_SZ_LSB +: 2]         = regs_q.size;
                rd_data[CTRL_CNT_LSB +: CNT_W]    = regs_q.cnt;
            end
            OPC_DATA: rd_data = regs_q.data;
            default: rd_data = '0;
        endcase
    end

    assign addr_o = regs_q.addr;
    assign data_o = regs_q.data;

endmodule

// File: rtl/dra_bus_master.sv
module dra_bus_master
    import dra_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_dir,
    input  logic [1:0]        start_size,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              done_err
);

    localparam logic [CNT_W-1:0] ONE_BEAT = CNT_W'(1);

    typedef struct packed {
        logic              active;
        logic              we;
        logic [1:0]        size;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
    } mst_t;

    mst_t mst_d, mst_q;

    logic [1:0]        size_n;
    logic [ADDR_W-1:0] step;
    logic              beat_ok;
    logic              beat_err;

    function automatic logic [ADDR_W-1:0] align_to(input logic [ADDR_W-1:0] a,
                                                   input logic [1:0] sz);
        logic [ADDR_W-1:0] r;
        r = a;
        if (sz == SZ_HALF) begin
            r[0] = 1'b0;
        end else if (sz == SZ_WORD) begin
            r[1:0] = 2'b00;
        end
        return r;
    endfunction

    always_comb begin
        mst_d    = mst_q;
        done     = 1'b0;
        done_err = 1'b0;
        rd_valid = 1'b0;
        size_n   = (start_size == SZ_RSVD) ? SZ_WORD : start_size;
        step     = ADDR_W'(1) << mst_q.size;
        beat_ok  = mst_q.active && bus_ack && !bus_err;
        beat_err = mst_q.active && bus_ack && bus_err;

        if (start) begin
            mst_d.active = 1'b1;
            mst_d.we     = !start_dir;
            mst_d.size   = size_n;
            mst_d.addr   = align_to(start_addr, size_n);
            mst_d.left   = (start_cnt == '0) ? ONE_BEAT : start_cnt;
        end else if (beat_err) begin
            mst_d.active = 1'b0;
            done         = 1'b1;
            done_err     = 1'b1;
        end else if (beat_ok) begin
            rd_valid = !mst_q.we;
            if (mst_q.left == ONE_BEAT) begin
                mst_d.active = 1'b0;
                done         = 1'b1;
            end else begin
                mst_d.left = mst_q.left - ONE_BEAT;
                mst_d.addr = mst_q.addr + step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_q <= '0;
        end else begin
            mst_q <= mst_d;
        end
    end

    assign bus_req   = mst_q.active;
    assign bus_we    = mst_q.we;
    assign bus_addr  = mst_q.addr;
    assign bus_size  = mst_q.size;
    assign bus_wdata = wdata;
    assign rd_data   = bus_rdata;

endmodule

// File: rtl/dra_rsp_out.sv
module dra_rsp_out
    import dra_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TC_W-1:0]   ld_tcode,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [TC_W-1:0]   rsp_tcode,
    output logic [DATA_W-1:0] rsp_data
);

    typedef struct packed {
        logic              valid;
        logic [TC_W-1:0]   tcode;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = rsp_q;
        if (rsp_q.valid && rsp_ready) begin
            rsp_d.valid = 1'b0;
        end
        if (load) begin
            rsp_d.valid = 1'b1;
            rsp_d.tcode = ld_tcode;
            rsp_d.data  = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_tcode = rsp_q.tcode;
    assign rsp_data  = rsp_q.data;

endmodule

// File: rtl/dbg_reg_access.sv
module dbg_reg_access
    import dra_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TC_W-1:0]   req_tcode,
    input  logic [OP_W-1:0]   req_opcode,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [TC_W-1:0]   rsp_tcode,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    typedef struct packed {
        ctl_state_e state;
    } top_t;

    top_t top_d, top_q;

    logic              accept;
    logic              is_wr;
    logic              is_rd;
    logic              reg_wr_en;
    logic              launch;
    logic [DATA_W-1:0] reg_rd_data;
    logic [ADDR_W-1:0] cfg_addr;
    logic [DATA_W-1:0] cfg_data;
    logic              mst_done;
    logic              mst_err;
    logic              mst_rd_valid;
    logic [DATA_W-1:0] mst_rd_data;
    logic              rsp_load;
    logic [TC_W-1:0]   rsp_ld_tcode;
    logic [DATA_W-1:0] rsp_ld_data;
    logic              sc_clr;

    assign req_ready = (top_q.state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign is_wr     = (req_tcode == TC_WR_REQ);
    assign is_rd     = (req_tcode == TC_RD_REQ);
    assign reg_wr_en = accept && is_wr;
    assign launch    = reg_wr_en && (req_opcode == OPC_CTRL) && req_data[CTRL_SC_BIT];

    always_comb begin
        top_d        = top_q;
        rsp_load     = 1'b0;
        rsp_ld_tcode = TC_READY;
        rsp_ld_data  = '0;
        sc_clr       = 1'b0;
        case (top_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (launch) begin
                        top_d.state = ST_BUSY;
                    end else begin
                        rsp_load    = 1'b1;
                        top_d.state = ST_REPLY;
                        if (is_rd) begin
                            rsp_ld_tcode = TC_RD_RSP;
                            rsp_ld_data  = reg_rd_data;
                        end
                    end
                end
            end
            ST_BUSY: begin
                if (mst_done) begin
                    sc_clr      = 1'b1;
                    rsp_load    = 1'b1;
                    top_d.state = ST_REPLY;
                    if (mst_err) begin
                        rsp_ld_tcode = TC_ERROR;
                        rsp_ld_data  = DATA_W'(ERR_ADDR);
                    end
                end
            end
            ST_REPLY: begin
                if (rsp_valid && rsp_ready) begin
                    top_d.state = ST_IDLE;
                end
            end
            default: top_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.state <= ST_IDLE;
        end else begin
            top_q <= top_d;
        end
    end

    dra_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_opc   (req_opcode),
        .wr_data  (req_data),
        .sc_clr   (sc_clr),
        .upd_en   (mst_rd_valid),
        .upd_data (mst_rd_data),
        .rd_opc   (req_opcode),
        .rd_data  (reg_rd_data),
        .addr_o   (cfg_addr),
        .data_o   (cfg_data)
    );

    dra_bus_master #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_bus_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (launch),
        .start_addr (cfg_addr),
        .start_dir  (req_data[CTRL_DIR_BIT]),
        .start_size (req_data[CTRL_SZ_LSB +: 2]),
        .start_cnt  (req_data[CTRL_CNT_LSB +: CNT_W]),
        .wdata      (cfg_data),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .rd_valid   (mst_rd_valid),
        .rd_data    (mst_rd_data),
        .done       (mst_done),
        .done_err   (mst_err)
    );

    dra_rsp_out #(
        .DATA_W (DATA_W)
    ) i_rsp_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rsp_load),
        .ld_tcode  (rsp_ld_tcode),
        .ld_data   (rsp_ld_data),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_tcode (rsp_tcode),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/dra_checker.sv
module dra_checker
    import dra_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [TC_W-1:0]   rsp_tcode,
    input logic [DATA_W-1:0] rsp_data,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size
);

    assert_rsp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tcode) && $stable(rsp_data));

    assert_one_at_a_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid);

    assert_word_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_size == SZ_WORD) |-> (bus_addr[1:0] == 2'b00));

    assert_half_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && (bus_size == SZ_HALF) |-> (bus_addr[0] == 1'b0));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr));

    assert_err_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_err |=> !bus_req);

    assert_err_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_tcode == TC_ERROR) |-> (rsp_data == DATA_W'(ERR_ADDR)));

    assert_tcode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_tcode == TC_READY || rsp_tcode == TC_RD_RSP || rsp_tcode == TC_ERROR));

endmodule

bind dbg_reg_access dra_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_dra_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_tcode (rsp_tcode),
    .rsp_data  (rsp_data),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size)
);

// File: tb/test_dbg_reg_access.sv
module test_dbg_reg_access;
    import dra_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_tcode = '0;
    logic [7:0]  req_opcode = '0;
    logic [31:0] req_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [5:0]  rsp_tcode;
    logic [31:0] rsp_data;
    logic        bus_req;
    logic        bus_we;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int          lat = 0;
    int          err_at = -1;
    int          wait_cnt = 0;
    int          beat_n = 0;
    logic [31:0] b_addr [128];
    logic        b_we   [128];
    logic [31:0] b_wd   [128];

    always #10 clk = ~clk;

    dbg_reg_access i_dbg_reg_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_tcode  (req_tcode),
        .req_opcode (req_opcode),
        .req_data   (req_data),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_tcode  (rsp_tcode),
        .rsp_data   (rsp_data),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_size   (bus_size),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err)
    );

    // bus slave model: acknowledges after lat idle cycles, records each beat
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack  <= 1'b0;
            bus_err  <= 1'b0;
            wait_cnt <= 0;
        end else if (bus_ack) begin
            bus_ack  <= 1'b0;
            bus_err  <= 1'b0;
            wait_cnt <= 0;
        end else if (bus_req) begin
            if (wait_cnt >= lat) begin
                bus_ack        <= 1'b1;
                bus_err        <= (beat_n == err_at);
                bus_rdata      <= 32'hC0DE0000 ^ bus_addr;
                b_addr[beat_n] <= bus_addr;
                b_we[beat_n]   <= bus_we;
                b_wd[beat_n]   <= bus_wdata;
                beat_n         <= beat_n + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    function automatic logic [31:0] mk_ctrl(input bit sc, input bit dir,
                                            input logic [1:0] sz, input logic [7:0] cnt);
        return {16'h0, cnt, 4'h0, sz, dir, sc};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [5:0] tc, input logic [7:0] op, input logic [31:0] dat,
                        output logic [5:0] rtc, output logic [31:0] rdat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_tcode  = tc;
        req_opcode = op;
        req_data   = dat;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rtc  = rsp_tcode;
        rdat = rsp_data;
        chk("R4 no request taken while reply pending", {31'h0, req_ready}, 32'h0);
        @(negedge clk);
        chk("R4 reply held while not taken", {26'h0, rsp_tcode}, {26'h0, rtc});
        chk("R4 reply data held", rsp_data, rdat);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] op, input logic [31:0] dat, input string req);
        logic [5:0]  t;
        logic [31:0] d;
        xfer(TC_WR_REQ, op, dat, t, d);
        chk({req, " write ready code"}, {26'h0, t}, {26'h0, TC_READY});
        chk({req, " write ready data"}, d, 32'h0);
    endtask

    task automatic rd_reg(input logic [7:0] op, input logic [31:0] exp, input string req);
        logic [5:0]  t;
        logic [31:0] d;
        xfer(TC_RD_REQ, op, 32'h0, t, d);
        chk({req, " read code"}, {26'h0, t}, {26'h0, TC_RD_RSP});
        chk({req, " read data"}, d, exp);
    endtask

    task automatic launch(input logic [31:0] ctrl, output logic [5:0] t, output logic [31:0] d);
        xfer(TC_WR_REQ, OPC_CTRL, ctrl, t, d);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R4 reset ready", {31'h0, req_ready}, 32'h1);
        chk("R4 reset no reply", {31'h0, rsp_valid}, 32'h0);
        chk("R11 reset bus idle", {31'h0, bus_req}, 32'h0);
    endtask

    task automatic t_regs();
        int b0;
        wr_reg(OPC_DATA, 32'hDEADBEEF, "R1");
        rd_reg(OPC_DATA, 32'hDEADBEEF, "R2");
        wr_reg(OPC_ADDR, 32'h00ABCDEF, "R1");
        rd_reg(OPC_ADDR, 32'h00ABCDEF, "R2");
        b0 = beat_n;
        wr_reg(OPC_CTRL, mk_ctrl(1'b0, 1'b1, 2'd1, 8'd3), "R1");
        repeat (4) @(negedge clk);
        chk("R5 no start no bus cycle", beat_n - b0, 0);
        rd_reg(OPC_CTRL, 32'h0000_0306, "R2");
    endtask

    task automatic t_unknown();
        logic [5:0]  t;
        logic [31:0] d;
        wr_reg(8'h33, 32'h11112222, "R3");
        rd_reg(OPC_DATA, 32'hDEADBEEF, "R3 unknown opcode no write");
        xfer(6'd5, OPC_DATA, 32'h33334444, t, d);
        chk("R3 unknown code ready", {26'h0, t}, {26'h0, TC_READY});
        rd_reg(OPC_DATA, 32'hDEADBEEF, "R3 unknown code no write");
        rd_reg(8'h33, 32'h0, "R3 unknown opcode read");
    endtask

    task automatic t_word_read();
        logic [5:0]  t;
        logic [31:0] d;
        int b0;
        wr_reg(OPC_ADDR, 32'h0000_1003, "R1");
        b0 = beat_n;
        launch(mk_ctrl(1'b1, 1'b1, 2'd2, 8'd1), t, d);
        chk("R5 ready after bus", {26'h0, t}, {26'h0, TC_READY});
        chk("R5 beat done before reply", beat_n - b0, 1);
        chk("R6 word align", b_addr[b0], 32'h0000_1000);
        rd_reg(OPC_DATA, 32'hC0DE1000, "R8");
        rd_reg(OPC_CTRL, 32'h0000_010A, "R5 start bit cleared");
    endtask

    task automatic t_block_half();
        logic [5:0]  t;
        logic [31:0] d;
        int b0;
        wr_reg(OPC_ADDR, 32'h0000_2001, "R1");
        b0 = beat_n;
        launch(mk_ctrl(1'b1, 1'b1, 2'd1, 8'd3), t, d);
        chk("R7 block ready", {26'h0, t}, {26'h0, TC_READY});
        chk("R7 three beats", beat_n - b0, 3);
        chk("R6 half align beat0", b_addr[b0], 32'h0000_2000);
        chk("R7 half step beat1", b_addr[b0+1], 32'h0000_2002);
        chk("R7 half step beat2", b_addr[b0+2], 32'h0000_2004);
        rd_reg(OPC_DATA, 32'hC0DE2004, "R8 last beat kept");
    endtask

    task automatic t_block_byte_write();
        logic [5:0]  t;
        logic [31:0] d;
        int b0;
        wr_reg(OPC_DATA, 32'h12345678, "R1");
        wr_reg(OPC_ADDR, 32'h0000_3001, "R1");
        b0 = beat_n;
        launch(mk_ctrl(1'b1, 1'b0, 2'd0, 8'd2), t, d);
        chk("R7 byte block ready", {26'h0, t}, {26'h0, TC_READY});
        chk("R7 two beats", beat_n - b0, 2);
        chk("R6 byte unaligned kept", b_addr[b0], 32'h0000_3001);
        chk("R7 byte step", b_addr[b0+1], 32'h0000_3002);
        chk("R9 write strobe", {31'h0, b_we[b0]}, 32'h1);
        chk("R9 write data", b_wd[b0+1], 32'h12345678);
    endtask

    task automatic t_count_zero();
        logic [5:0]  t;
        logic [31:0] d;
        int b0;
        wr_reg(OPC_ADDR, 32'h0000_5006, "R1");
        b0 = beat_n;
        launch(mk_ctrl(1'b1, 1'b1, 2'd2, 8'd0), t, d);
        chk("R7 count zero ready", {26'h0, t}, {26'h0, TC_READY});
        chk("R7 count zero one beat", beat_n - b0, 1);
        chk("R6 word align 5006", b_addr[b0], 32'h0000_5004);
    endtask

    task automatic t_error();
        logic [5:0]  t;
        logic [31:0] d;
        int b0;
        wr_reg(OPC_ADDR, 32'h0000_4000, "R1");
        b0 = beat_n;
        err_at = b0 + 1;
        launch(mk_ctrl(1'b1, 1'b1, 2'd2, 8'd4), t, d);
        chk("R10 error code", {26'h0, t}, {26'h0, TC_ERROR});
        chk("R10 error data", d, 32'h0000_0003);
        repeat (5) @(negedge clk);
        chk("R10 no beats after error", beat_n - b0, 2);
        chk("R10 bus idle after error", {31'h0, bus_req}, 32'h0);
        err_at = -1;
        rd_reg(OPC_DATA, 32'hC0DE4000, "R10 good beat kept");
        rd_reg(OPC_CTRL, 32'h0000_040A, "R10 start bit cleared");
    endtask

    task automatic t_latency();
        logic [5:0]  t;
        logic [31:0] d;
        int b0;
        lat = 2;
        wr_reg(OPC_DATA, 32'hA5A50F0F, "R1");
        wr_reg(OPC_ADDR, 32'h0000_6000, "R1");
        b0 = beat_n;
        launch(mk_ctrl(1'b1, 1'b0, 2'd2, 8'd2), t, d);
        chk("R11 slow bus ready", {26'h0, t}, {26'h0, TC_READY});
        chk("R11 slow bus beats", beat_n - b0, 2);
        chk("R11 held address beat0", b_addr[b0], 32'h0000_6000);
        chk("R11 held address beat1", b_addr[b0+1], 32'h0000_6004);
        chk("R9 slow write data", b_wd[b0], 32'hA5A50F0F);
        lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_unknown();
        t_word_read();
        t_block_half();
        t_block_byte_write();
        t_count_zero();
        t_error();
        t_latency();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule